// File: doc/BRIEF.md
# I2C Byte-Level Master Controller

This block drives an I2C bus as its only master, one byte at a time, under the control of a small register file. Software writes a byte into the data buffer, then writes the control register with the transfer-byte bit set together with per-byte qualifiers. These ask for a START before the byte, a STOP after it, and the value the master places in the acknowledge slot of a byte it reads. The engine produces the bus conditions, shifts the byte out or in most significant bit first, and samples or drives the acknowledge bit. It then sets a transmit-empty or a receive-full flag. A separate abort bit ends a held transaction with a STOP that carries no data.

SCL and SDA are open-drain. Each line has an input, an output enable that pulls the line low when high, and an output tied to 0. A divider parameter sets the length of every SCL half period. A high half is counted only while SCL is seen high on the input, so a target that stretches the clock lengthens it. The register port is a plain write strobe with a combinational read mux. There is no stream interface. Flow control comes from the byte handshake alone: after each byte without STOP, the engine holds SCL low and stalls the bus for as long as software takes to set the transfer-byte bit or the abort bit again.

Register offsets: 0 control, 1 status, 2 data buffer, 3 slave address. Control bits: 0 START, 1 STOP, 2 ACK/NAK select, 3 transfer-byte, 4 abort, 5 transmit-empty interrupt enable, 6 receive-full interrupt enable, 7 arbitration-loss interrupt enable. Status bits: 0 latched read direction, 1 acknowledge value seen on the bus, 2 busy, 3 arbitration loss, 4 transmit empty, 5 receive full.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the control, status and data registers read 0, both line enables are 0 and irq is 0. The slave address register (offset 3, low 7 bits) keeps the value written before the reset.
- R2: When transfer-byte is accepted with START set, or from idle, the engine first makes SDA fall while SCL is high, then sends the buffer. The buffer's bit 0 is latched as the direction (1 = read) and appears in status bit 0. Status bit 2 (busy) is 1 from acceptance until the closing STOP ends.
- R3: When a transmitted byte completes, status bit 4 is set and status bit 1 holds the SDA value sampled in the acknowledge slot (0 = acknowledged, 1 = not acknowledged).
- R4: When a received byte completes, status bit 5 is set and the data register holds the 8 bits sampled from SDA, first bit in bit 7.
- R5: In the acknowledge slot of a received byte, the master pulls SDA low when control bit 2 was 0 at acceptance and releases it when that bit was 1. Status bit 1 reports the value.
- R6: With STOP (control bit 1) clear at acceptance, the engine holds SCL low and stays busy after the byte. With STOP set, it generates a STOP (SDA rising while SCL is high) and clears busy.
- R7: Transfer-byte accepted with START set while the bus is held produces a repeated START followed by the new address byte, with the direction re-latched.
- R8: Setting the abort bit (control bit 4) while the bus is held generates a STOP with no data bits. The engine returns to idle with busy 0, and the abort bit reads 0 afterwards.
- R9: Status bits 3, 4 and 5 are cleared by writing 1 to their positions. Writing 0 leaves them set.
- R10: The transfer-byte bit reads 0 once the engine accepts it. A write that sets it while a byte or bus condition is in progress is ignored and starts no further byte.
- R11: irq is 1 exactly when some status flag among bits 3, 4 and 5 is set and its enable (control bits 7, 5 and 6 respectively) is 1.
- R12: If the master releases SDA for a 1 bit of a byte it sends and samples SDA low, status bit 3 (arbitration loss) is set.
- R13: Every SCL high and low level lasts at least HALF_CYCLES clocks. With no clock stretching, a data-bit high phase lasts exactly HALF_CYCLES clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt, OR of enabled status flags |
| scl_i | input | 1 | SCL line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_o | output | 1 | SCL output value, constant 0 |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_o | output | 1 | SDA output value, constant 0 |

## Verification
On every cycle the assertions check that SCL levels never last less than a half period and that SDA moves under a high SCL only when forming START or STOP. They also check that an accepted or ignored transfer-byte bit reads back 0, that a received byte lands in the data register, that a zero write does not clear a flag, and that an abort leads straight into STOP. Only the bench's scenarios can show the bus-level results. These are acknowledge values seen from a responding and from a silent target, bytes read back MSB-first, the repeated START with re-latched direction, the absence of a second byte after an ignored write, interrupt gating, and the slave address surviving reset.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);

  typedef enum logic [3:0] {
    ST_IDLE, ST_START_A, ST_START_B, ST_RS_A,
    ST_BIT_LO, ST_BIT_HI, ST_ACK_LO, ST_ACK_HI,
    ST_HOLD, ST_STOP_A, ST_STOP_B, ST_STOP_C
  } eng_state_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_SADR = 2'd3;

  localparam int C_START  = 0;
  localparam int C_STOP   = 1;
  localparam int C_ACKNAK = 2;
  localparam int C_TB     = 3;
  localparam int C_MA     = 4;
  localparam int C_TEIE   = 5;
  localparam int C_RFIE   = 6;
  localparam int C_ALIE   = 7;

  localparam int S_RW   = 0;
  localparam int S_ACK  = 1;
  localparam int S_BUSY = 2;
  localparam int S_AL   = 3;
  localparam int S_ITE  = 4;
  localparam int S_IRF  = 5;
endpackage

// File: rtl/i2cm_halftick.sv
module i2cm_halftick #(
  parameter int HALF_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF_CYCLES + 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(HALF_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int HALF_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tb_req,
  input  logic              start_q,
  input  logic              stop_q,
  input  logic              acknak_q,
  input  logic              ma_req,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              tb_ack,
  output logic              ma_ack,
  output logic              busy,
  output logic              shifting,
  output logic              dir_rw,
  output logic              ack_seen,
  output logic              tx_done,
  output logic              rx_done,
  output logic              al_evt,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              scl_low,
  output logic              sda_low
);
  localparam int SW = $clog2(HALF_CYCLES + 1) + 1;

  eng_state_t        state;
  logic [BYTE_W-1:0] shreg;
  logic [BIT_W-1:0]  bitcnt;
  logic              rx_mode, stop_l, acknak_l;
  logic              waiting, timed, run, tick;

  assign waiting  = (state == ST_IDLE) || (state == ST_HOLD);
  assign busy     = (state != ST_IDLE);
  assign shifting = busy && (state != ST_HOLD);
  assign ma_ack   = ma_req && waiting;
  assign tb_ack   = tb_req && !ma_req && waiting;
  assign rx_byte  = shreg;

  always_comb begin
    case (state)
      ST_RS_A, ST_BIT_LO, ST_ACK_LO, ST_HOLD, ST_STOP_A: scl_low = 1'b1;
      default:                                            scl_low = 1'b0;
    endcase
  end

  always_comb begin
    case (state)
      ST_START_B, ST_STOP_A, ST_STOP_B: sda_low = 1'b1;
      ST_BIT_LO, ST_BIT_HI:             sda_low = !rx_mode && !shreg[BYTE_W-1];
      ST_ACK_LO, ST_ACK_HI:             sda_low = rx_mode && !acknak_l;
      default:                          sda_low = 1'b0;
    endcase
  end

  // A high half only counts while the line is actually high.
  assign timed = !waiting;
  assign run   = timed && (scl_low || scl_in);

  i2cm_halftick #(.HALF_CYCLES(HALF_CYCLES)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      bitcnt   <= '0;
      rx_mode  <= 1'b0;
      stop_l   <= 1'b0;
      acknak_l <= 1'b0;
      dir_rw   <= 1'b0;
      ack_seen <= 1'b0;
      tx_done  <= 1'b0;
      rx_done  <= 1'b0;
      al_evt   <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      rx_done <= 1'b0;
      al_evt  <= 1'b0;
      case (state)
        ST_IDLE: if (tb_ack) begin
          shreg    <= tx_byte;
          stop_l   <= stop_q;
          acknak_l <= acknak_q;
          bitcnt   <= '0;
          dir_rw   <= tx_byte[0];
          rx_mode  <= 1'b0;
          state    <= ST_START_A;
        end
        ST_HOLD: begin
          if (ma_req) state <= ST_STOP_A;
          else if (tb_ack) begin
            shreg    <= tx_byte;
            stop_l   <= stop_q;
            acknak_l <= acknak_q;
            bitcnt   <= '0;
            if (start_q) begin
              dir_rw  <= tx_byte[0];
              rx_mode <= 1'b0;
              state   <= ST_RS_A;
            end else begin
              rx_mode <= dir_rw;
              state   <= ST_BIT_LO;
            end
          end
        end
        ST_RS_A:    if (tick) state <= ST_START_A;
        ST_START_A: if (tick) state <= ST_START_B;
        ST_START_B: if (tick) state <= ST_BIT_LO;
        ST_BIT_LO:  if (tick) state <= ST_BIT_HI;
        ST_BIT_HI: if (tick) begin
          if (!rx_mode && shreg[BYTE_W-1] && !sda_in) al_evt <= 1'b1;
          shreg  <= {shreg[BYTE_W-2:0], sda_in};
          bitcnt <= bitcnt + 1'b1;
          state  <= (bitcnt == BIT_W'(BYTE_W - 1)) ? ST_ACK_LO : ST_BIT_LO;
        end
        ST_ACK_LO:  if (tick) state <= ST_ACK_HI;
        ST_ACK_HI: if (tick) begin
          ack_seen <= sda_in;
          tx_done  <= !rx_mode;
          rx_done  <= rx_mode;
          state    <= stop_l ? ST_STOP_A : ST_HOLD;
        end
        ST_STOP_A:  if (tick) state <= ST_STOP_B;
        ST_STOP_B:  if (tick) state <= ST_STOP_C;
        ST_STOP_C:  if (tick) state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  // Checker: length of the current SCL level, saturating.
  logic          scl_prev;
  logic [SW-1:0] since_edge;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev   <= 1'b0;
      since_edge <= SW'(HALF_CYCLES);
    end else begin
      scl_prev <= scl_low;
      if (scl_low != scl_prev)              since_edge <= SW'(1);
      else if (since_edge < SW'(HALF_CYCLES)) since_edge <= since_edge + 1'b1;
    end
  end

  assert_scl_half_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_low != scl_prev) |-> (since_edge >= SW'(HALF_CYCLES)));

  assert_sda_under_high_scl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(scl_low) && !scl_low && (sda_low != $past(sda_low)))
      |-> (state == ST_START_B || state == ST_STOP_C));

  assert_abort_to_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ma_ack && state == ST_HOLD) |=> (state == ST_STOP_A));
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              tb_ack,
  input  logic              ma_ack,
  input  logic              busy,
  input  logic              shifting,
  input  logic              dir_rw,
  input  logic              ack_seen,
  input  logic              tx_done,
  input  logic              rx_done,
  input  logic              al_evt,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              ctl_tb,
  output logic              ctl_start,
  output logic              ctl_stop,
  output logic              ctl_acknak,
  output logic              ctl_ma,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);
  logic [BYTE_W-1:0] ctrl_q, ctrl_d, data_q;
  logic [6:0]        sadr_q;
  logic              al_q, ite_q, irf_q;
  logic              wr_ctrl, wr_stat, wr_data;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_stat = wr_en && (addr == A_STAT);
  assign wr_data = wr_en && (addr == A_DATA);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d = wdata;
      if (shifting) ctrl_d[C_TB] = ctrl_q[C_TB];
    end
    if (tb_ack) ctrl_d[C_TB] = 1'b0;
    if (ma_ack) ctrl_d[C_MA] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
      al_q   <= 1'b0;
      ite_q  <= 1'b0;
      irf_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      if (rx_done)      data_q <= rx_byte;
      else if (wr_data) data_q <= wdata;
      if (al_evt)                        al_q  <= 1'b1;
      else if (wr_stat && wdata[S_AL])   al_q  <= 1'b0;
      if (tx_done)                       ite_q <= 1'b1;
      else if (wr_stat && wdata[S_ITE])  ite_q <= 1'b0;
      if (rx_done)                       irf_q <= 1'b1;
      else if (wr_stat && wdata[S_IRF])  irf_q <= 1'b0;
    end
  end

  // Address storage deliberately outside the reset domain.
  always_ff @(posedge clk) begin
    if (wr_en && addr == A_SADR) sadr_q <= wdata[6:0];
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrl_q;
      A_STAT:  rdata = {2'b00, irf_q, ite_q, al_q, busy, ack_seen, dir_rw};
      A_DATA:  rdata = data_q;
      default: rdata = {1'b0, sadr_q};
    endcase
  end

  assign ctl_tb     = ctrl_q[C_TB];
  assign ctl_start  = ctrl_q[C_START];
  assign ctl_stop   = ctrl_q[C_STOP];
  assign ctl_acknak = ctrl_q[C_ACKNAK];
  assign ctl_ma     = ctrl_q[C_MA];
  assign tx_byte    = data_q;
  assign irq = (ite_q && ctrl_q[C_TEIE]) || (irf_q && ctrl_q[C_RFIE]) ||
               (al_q && ctrl_q[C_ALIE]);

  assert_tb_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tb_ack |=> !ctl_tb);

  assert_tb_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && shifting && !ctl_tb) |=> !ctl_tb);

  assert_rx_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> (tx_byte == $past(rx_byte)));

  assert_w1c_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !wdata[S_ITE] && ite_q) |=> ite_q);
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int HALF_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_i,
  output logic       scl_oe,
  output logic       scl_o,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       sda_o
);
  logic              tb_ack, ma_ack, busy, shifting, dir_rw, ack_seen;
  logic              tx_done, rx_done, al_evt;
  logic              ctl_tb, ctl_start, ctl_stop, ctl_acknak, ctl_ma;
  logic [BYTE_W-1:0] rx_byte, tx_byte;
  logic              scl_low, sda_low;

  i2cm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .tb_ack(tb_ack), .ma_ack(ma_ack), .busy(busy), .shifting(shifting),
    .dir_rw(dir_rw), .ack_seen(ack_seen), .tx_done(tx_done),
    .rx_done(rx_done), .al_evt(al_evt), .rx_byte(rx_byte),
    .ctl_tb(ctl_tb), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
    .ctl_acknak(ctl_acknak), .ctl_ma(ctl_ma), .tx_byte(tx_byte), .irq(irq)
  );

  i2cm_engine #(.HALF_CYCLES(HALF_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n), .tb_req(ctl_tb), .start_q(ctl_start),
    .stop_q(ctl_stop), .acknak_q(ctl_acknak), .ma_req(ctl_ma),
    .tx_byte(tx_byte), .scl_in(scl_i), .sda_in(sda_i),
    .tb_ack(tb_ack), .ma_ack(ma_ack), .busy(busy), .shifting(shifting),
    .dir_rw(dir_rw), .ack_seen(ack_seen), .tx_done(tx_done),
    .rx_done(rx_done), .al_evt(al_evt), .rx_byte(rx_byte),
    .scl_low(scl_low), .sda_low(sda_low)
  );

  assign scl_oe = scl_low;
  assign sda_oe = sda_low;
  assign scl_o  = 1'b0;
  assign sda_o  = 1'b0;
endmodule

// File: tb/i2c_byte_master_tb_top.sv
`timescale 1ns/1ps
module i2c_byte_master_tb_top;
  localparam int HALF = 4;
  localparam logic [6:0] SLV = 7'h2D;
  // {byte, control, expected ack bit}
  localparam logic [16:0] VEC [0:3] = '{
    {8'h5A, 8'h29, 1'b0},
    {8'h96, 8'h28, 1'b0},
    {8'h0F, 8'h2A, 1'b0},
    {8'h40, 8'h2B, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq, scl_oe, scl_o, sda_oe, sda_o;
  logic s_drive = 0, jam = 0;
  wire  scl_line = ~scl_oe;
  wire  sda_line = ~(sda_oe | s_drive | jam);

  int total = 0, bad = 0;
  int bitcnt = 0, byte_idx = 0, starts = 0, stops = 0;
  logic [7:0] sh = 0, last_byte = 0;
  logic is_read = 0, matched = 0, done = 0, scl_p = 1, sda_p = 1;

  always #2 clk = ~clk;

  i2c_byte_master #(.HALF_CYCLES(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_i(scl_line), .scl_oe(scl_oe), .scl_o(scl_o),
    .sda_i(sda_line), .sda_oe(sda_oe), .sda_o(sda_o)
  );

  // Target model sampled away from the active edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      bitcnt = 0; byte_idx = 0; is_read = 0; matched = 0; done = 0;
      s_drive = 0; scl_p = 1; sda_p = 1;
    end else begin
      if (scl_p && scl_line && sda_p && !sda_line) begin
        bitcnt = 0; byte_idx = 0; is_read = 0; matched = 0; done = 0; starts++;
      end else if (scl_p && scl_line && !sda_p && sda_line) begin
        stops++; matched = 0; s_drive = 0;
      end else if (!scl_p && scl_line) begin
        if (bitcnt < 8) begin
          sh = {sh[6:0], sda_line}; bitcnt++;
          if (bitcnt == 8) begin
            last_byte = sh;
            if (byte_idx == 0) begin is_read = sh[0]; matched = (sh[7:1] == SLV); end
          end
        end else begin
          if (is_read && byte_idx > 0 && sda_line) done = 1;
          bitcnt = 0; byte_idx++;
        end
      end else if (scl_p && !scl_line) begin
        if (bitcnt == 8) s_drive = matched && (byte_idx == 0 || !is_read);
        else if (matched && is_read && byte_idx > 0 && !done)
          s_drive = !(((byte_idx == 1) ? 8'hC6 : 8'h3B) >> (7 - bitcnt) & 8'h01);
        else s_drive = 0;
      end
      scl_p = scl_line; sda_p = sda_line;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_stat(input logic [7:0] mask, input string req);
    logic [7:0] s;
    int n;
    n = 0;
    do begin rd(2'd1, s); n++; end while (((s & mask) == 0) && n < 4000);
    if (n >= 4000) chk(req, s & mask, mask);
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] s;
    int n;
    n = 0;
    do begin rd(2'd1, s); n++; end while (s[2] && n < 4000);
    chk(req, {7'd0, s[2]}, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n, st0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    wr(2'd3, {1'b0, SLV});
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk); rst_n = 1;
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd1, v); chk("R1 status", v, 8'h00);
    rd(2'd2, v); chk("R1 data", v, 8'h00);
    rd(2'd3, v); chk("R1 slave address kept", v, {1'b0, SLV});
    chk("R1 lines/irq", {5'd0, scl_oe, sda_oe, irq}, 8'h00);

    // Vector table: writes with and without a responding target
    for (int i = 0; i < 4; i++) begin
      wr(2'd2, VEC[i][16:9]);
      wr(2'd0, VEC[i][8:1]);
      if (i == 1) begin
        n = 0;
        while (!scl_line) @(negedge clk);
        while (scl_line) begin @(negedge clk); n++; end
        chk("R13 high half", 8'(n), 8'(HALF));
      end
      n = 0;
      while (!irq && n < 4000) begin @(negedge clk); n++; end
      rd(2'd1, v);
      chk("R3 ite flag", {7'd0, v[4]}, 8'h01);
      chk("R3 ack bit", {7'd0, v[1]}, {7'd0, VEC[i][0]});
      chk("R2 direction", {7'd0, v[0]}, 8'h00);
      chk("R3 byte on bus", last_byte, VEC[i][16:9]);
      if (i == 0) begin
        rd(2'd0, v); chk("R10 tb self-clear", {7'd0, v[3]}, 8'h00);
      end
      if (VEC[i][2]) begin
        st0 = stops;
        wait_idle("R6 stop clears busy");
        chk("R6 stop seen", 8'(stops - st0), 8'h01);
      end else begin
        rd(2'd1, v);
        chk("R6 held busy/scl low", {6'd0, v[2], scl_oe}, 8'h03);
      end
      wr(2'd1, 8'h00);
      rd(2'd1, v); chk("R9 zero write keeps", {7'd0, v[4]}, 8'h01);
      wr(2'd1, 8'h10);
      rd(2'd1, v); chk("R9 w1c ite", {7'd0, v[4]}, 8'h00);
      chk("R11 irq low", {7'd0, irq}, 8'h00);
    end

    // Write address, repeated START into read, two bytes, NAK, abort
    wr(2'd2, {SLV, 1'b0}); wr(2'd0, 8'h29);
    wait_stat(8'h10, "R3 addr ite"); wr(2'd1, 8'h10);
    st0 = starts;
    wr(2'd2, {SLV, 1'b1}); wr(2'd0, 8'h29);
    wait_stat(8'h10, "R7 read addr ite");
    rd(2'd1, v);
    chk("R7 direction read/ack", {6'd0, v[1], v[0]}, 8'h01);
    chk("R7 repeated start", 8'(starts - st0), 8'h01);
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h48);
    wait_stat(8'h20, "R4 irf 1");
    chk("R11 rx irq", {7'd0, irq}, 8'h01);
    rd(2'd2, v); chk("R4 first byte", v, 8'hC6);
    rd(2'd1, v); chk("R5 ack driven low", {7'd0, v[1]}, 8'h00);
    wr(2'd1, 8'h20);
    wr(2'd0, 8'h4C);
    wait_stat(8'h20, "R4 irf 2");
    rd(2'd2, v); chk("R4 second byte", v, 8'h3B);
    rd(2'd1, v); chk("R5 nak released", {7'd0, v[1]}, 8'h01);
    wr(2'd1, 8'h20);
    st0 = stops;
    wr(2'd0, 8'h10);
    wait_idle("R8 abort idle");
    chk("R8 stop seen", 8'(stops - st0), 8'h01);
    rd(2'd0, v); chk("R8 abort bit clears", {7'd0, v[4]}, 8'h00);
    chk("R8 lines released", {6'd0, scl_oe, sda_oe}, 8'h00);

    // Transfer-byte write while shifting is ignored
    wr(2'd2, {SLV, 1'b0}); wr(2'd0, 8'h09);
    repeat (10) @(negedge clk);
    wr(2'd0, 8'h08);
    rd(2'd0, v); chk("R10 ignored write", {7'd0, v[3]}, 8'h00);
    wait_stat(8'h10, "R10 first byte");
    wr(2'd1, 8'h10);
    st0 = byte_idx;
    repeat (120) @(negedge clk);
    rd(2'd1, v);
    chk("R10 no second byte", {6'd0, v[4], v[2]}, 8'h01);
    chk("R10 target count", 8'(byte_idx - st0), 8'h00);
    wr(2'd0, 8'h10);
    wait_idle("R8 abort after ignore");

    // Arbitration loss and interrupt gating
    jam = 1;
    wr(2'd2, 8'hFF); wr(2'd0, 8'h09);
    wait_stat(8'h10, "R12 byte end");
    rd(2'd1, v); chk("R12 al flag", {7'd0, v[3]}, 8'h01);
    chk("R11 irq masked", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'h80);
    chk("R11 irq al enabled", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'h00);
    rd(2'd1, v); chk("R9 al kept", {7'd0, v[3]}, 8'h01);
    wr(2'd1, 8'h18);
    chk("R9 al cleared irq", {7'd0, irq}, 8'h00);
    jam = 0;
    wr(2'd0, 8'h10);
    wait_idle("R8 abort after al");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule